// File: doc/BRIEF.md
# Rally-Paced Step Enable Generator

This block sets the pace of the ball in a two-player LED rally game. It sends one-cycle step-enable pulses to the ball-path logic. A saturating rally counter counts successful paddle returns and is cleared when a player misses. The counter picks one of four step rates, so the ball speeds up as a rally gets longer and drops back to the slowest pace after a miss.

The block has one clock domain. Four free-running dividers each produce a slow square wave. Each wave has its own rising-edge detector. The step pulse is the registered edge of the wave that the current speed level selects. No derived signal ever drives a clock pin.

The speed level is held in a four-state machine:

- `SPD_SLOW` moves to `SPD_NORMAL` on a hit that takes the count from 3 to 4.
- `SPD_NORMAL` moves to `SPD_FAST` on a hit that takes the count from 6 to 7.
- `SPD_FAST` moves to `SPD_VFAST` on a hit that takes the count from 12 to 13.
- Every state returns to `SPD_SLOW` on a miss.
- Any other cycle holds the current state.

Top module: `rally_pacer`

## Requirements
- R1: Synchronous reset clears every divider, square wave, edge register, the rally count and the speed level. In the cycle after reset is released, `step_o`, `level_o` and `hits_o` are all 0.
- R2: Each cycle with `hit_i` high and `miss_i` low raises `hits_o` by one, visible after the next clock edge, while the count is below 15.
- R3: At a count of 15, further hits leave `hits_o` at 15.
- R4: A cycle with `miss_i` high clears `hits_o` to 0 and `level_o` to slow. This holds even when `hit_i` is high in the same cycle.
- R5: `level_o` is coded as follows, and it changes in the same cycle as `hits_o`:

  | Count | `level_o` | Speed |
  |---|---|---|
  | 0 to 3 | 2'b00 | slow |
  | 4 to 6 | 2'b01 | normal |
  | 7 to 12 | 2'b10 | fast |
  | 13 to 15 | 2'b11 | very fast |

- R6: Each divider's wave toggles on every edge n (counted from 1 after reset) for which n is a multiple of its terminal count T. The wave therefore rises on edges where n mod 2T equals T. `step_o` is high for exactly the one cycle after edge n+1, where n is such a rising edge of the wave selected at edge n+1. Under a constant level, pulses are spaced 2T cycles apart.
- R7: A change of level alone never produces a pulse. The new rate takes effect at the next rising edge of its own wave.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| hit_i | input | 1 | One-cycle pulse for a successful return |
| miss_i | input | 1 | One-cycle pulse for a missed ball |
| step_o | output | 1 | One-cycle step enable for the ball path |
| level_o | output | 2 | Current speed level code |
| hits_o | output | 4 | Current rally count |

## Verification
A wrong count or a wrong level-state register shows up at `hits_o` or `level_o` right after the clock edge that caused it. The bench compares both outputs against its own model on every cycle. A divider that drifts, or an edge detector that is in the wrong phase, moves a step pulse off its predicted cycle. This is caught no later than one wave period after the fault. A pulse that leaks through on a level switch appears on a cycle where the model predicts no pulse.

// File: rtl/pace_pkg.sv
package pace_pkg;
    localparam int unsigned HIT_W   = 4;
    localparam int unsigned HIT_MAX = 15;
    localparam int unsigned N_RATES = 4;

    typedef enum logic [1:0] {
        SPD_SLOW   = 2'b00,
        SPD_NORMAL = 2'b01,
        SPD_FAST   = 2'b10,
        SPD_VFAST  = 2'b11
    } speed_t;
endpackage

// File: rtl/rate_divider.sv
module rate_divider #(
    parameter int unsigned TERM = 25000000
) (
    input  logic clk,
    input  logic rst,
    output logic wave_o
);
    localparam int unsigned CW = $clog2(TERM + 1);
    localparam logic [CW-1:0] LAST = CW'(TERM - 1);

    logic [CW-1:0] cnt_q;
    logic          wave_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            wave_q <= 1'b0;
        end else if (cnt_q == LAST) begin
            cnt_q  <= '0;
            wave_q <= ~wave_q;
        end else begin
            cnt_q  <= cnt_q + 1'b1;
        end
    end

    assign wave_o = wave_q;

    AST_WAVE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (cnt_q != LAST) |=> $stable(wave_q)) else $error("wave moved early"); // R6
endmodule

// File: rtl/rally_tracker.sv
module rally_tracker
    import pace_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             hit_i,
    input  logic             miss_i,
    output logic [HIT_W-1:0] hits_o,
    output speed_t           level_o
);
    localparam logic [HIT_W-1:0] TOP = HIT_W'(HIT_MAX);

    logic [HIT_W-1:0] cnt_q;
    speed_t           state_q, state_d;
    logic             bump;

    assign bump = hit_i && !miss_i && (cnt_q != TOP);

    always_ff @(posedge clk) begin
        if (rst)         cnt_q <= '0;
        else if (miss_i) cnt_q <= '0;
        else if (bump)   cnt_q <= cnt_q + 1'b1;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SPD_SLOW:   if (miss_i) state_d = SPD_SLOW;
                        else if (bump && cnt_q == 4'd3)  state_d = SPD_NORMAL;
            SPD_NORMAL: if (miss_i) state_d = SPD_SLOW;
                        else if (bump && cnt_q == 4'd6)  state_d = SPD_FAST;
            SPD_FAST:   if (miss_i) state_d = SPD_SLOW;
                        else if (bump && cnt_q == 4'd12) state_d = SPD_VFAST;
            SPD_VFAST:  if (miss_i) state_d = SPD_SLOW;
            default:    state_d = SPD_SLOW;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= SPD_SLOW;
        else     state_q <= state_d;
    end

    always_comb begin
        hits_o  = cnt_q;
        level_o = state_q;
    end

    AST_HIT_STEP: assert property (@(posedge clk) disable iff (rst)
        (hit_i && !miss_i && cnt_q < TOP) |=> (cnt_q == $past(cnt_q) + 1'b1)) else $error("no increment"); // R2
    AST_SAT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (cnt_q == TOP && !miss_i) |=> (cnt_q == TOP)) else $error("saturation lost"); // R3
    AST_MISS_CLEAR: assert property (@(posedge clk) disable iff (rst)
        miss_i |=> (cnt_q == '0 && state_q == SPD_SLOW)) else $error("miss not cleared"); // R4
    AST_LEVEL_MAP: assert property (@(posedge clk) disable iff (rst)
        (state_q == SPD_SLOW)   == (cnt_q <= 4'd3) &&
        (state_q == SPD_NORMAL) == (cnt_q >= 4'd4 && cnt_q <= 4'd6) &&
        (state_q == SPD_VFAST)  == (cnt_q >= 4'd13)) else $error("level mismatch"); // R5
endmodule

// File: rtl/step_pacer.sv
module step_pacer
    import pace_pkg::*;
#(
    parameter int unsigned SLOW_TERM   = 25000000,
    parameter int unsigned NORMAL_TERM = 15000000,
    parameter int unsigned FAST_TERM   = 10000000,
    parameter int unsigned VFAST_TERM  = 7500000
) (
    input  logic   clk,
    input  logic   rst,
    input  speed_t level_i,
    output logic   step_o
);
    localparam int unsigned TERMS [N_RATES] = '{SLOW_TERM, NORMAL_TERM, FAST_TERM, VFAST_TERM};

    logic [N_RATES-1:0] wave, prev_q, rise;
    logic               step_q;

    for (genvar g = 0; g < N_RATES; g++) begin : g_rate
        rate_divider #(.TERM(TERMS[g])) u_div (
            .clk    (clk),
            .rst    (rst),
            .wave_o (wave[g])
        );
    end

    assign rise = wave & ~prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= '0;
            step_q <= 1'b0;
        end else begin
            prev_q <= wave;
            step_q <= rise[level_i];
        end
    end

    assign step_o = step_q;

    AST_QUIET_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !step_q) else $error("pulse after reset"); // R1
endmodule

// File: rtl/rally_pacer.sv
module rally_pacer
    import pace_pkg::*;
#(
    parameter int unsigned SLOW_TERM   = 25000000,
    parameter int unsigned NORMAL_TERM = 15000000,
    parameter int unsigned FAST_TERM   = 10000000,
    parameter int unsigned VFAST_TERM  = 7500000
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             hit_i,
    input  logic             miss_i,
    output logic             step_o,
    output logic [1:0]       level_o,
    output logic [HIT_W-1:0] hits_o
);
    speed_t level;

    rally_tracker u_track (
        .clk     (clk),
        .rst     (rst),
        .hit_i   (hit_i),
        .miss_i  (miss_i),
        .hits_o  (hits_o),
        .level_o (level)
    );

    step_pacer #(
        .SLOW_TERM   (SLOW_TERM),
        .NORMAL_TERM (NORMAL_TERM),
        .FAST_TERM   (FAST_TERM),
        .VFAST_TERM  (VFAST_TERM)
    ) u_pace (
        .clk     (clk),
        .rst     (rst),
        .level_i (level),
        .step_o  (step_o)
    );

    assign level_o = level;
endmodule

// File: tb/rally_pacer_bench.sv
module rally_pacer_bench;
    localparam int T0 = 10, T1 = 6, T2 = 4, T3 = 3;

    logic       clk = 1'b0, rst = 1'b1, hit = 1'b0, miss = 1'b0;
    logic       step;
    logic [1:0] level;
    logic [3:0] hits;

    int checks = 0, errors = 0, n = 0, mcnt = 0, mlvl = 0;
    logic exp_step = 1'b0;
    bit   done = 1'b0;

    always #2.5 clk = ~clk;

    rally_pacer #(.SLOW_TERM(T0), .NORMAL_TERM(T1), .FAST_TERM(T2), .VFAST_TERM(T3)) u_rally_pacer (
        .clk(clk), .rst(rst), .hit_i(hit), .miss_i(miss),
        .step_o(step), .level_o(level), .hits_o(hits)
    );

    function automatic int term_of(input int l);
        case (l) 0: return T0; 1: return T1; 2: return T2; default: return T3; endcase
    endfunction

    function automatic int map_lvl(input int c);
        if (c <= 3) return 0;
        if (c <= 6) return 1;
        if (c <= 12) return 2;
        return 3;
    endfunction

    // Reference model built from R2..R6
    always @(posedge clk) begin
        if (rst) begin
            n = 0; mcnt = 0; mlvl = 0; exp_step = 1'b0;
        end else begin
            n = n + 1;
            exp_step = (((n - 1) % (2 * term_of(mlvl))) == term_of(mlvl));
            if (miss) mcnt = 0;
            else if (hit && mcnt < 15) mcnt = mcnt + 1;
            mlvl = map_lvl(mcnt);
        end
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // Cycle monitor: step timing (R6 R7), level (R5), count (R2)
    always @(negedge clk) begin
        if (!rst && !done) begin
            check("R6 R7 step", step, exp_step);
            check("R5 level", level, mlvl);
            check("R2 count", hits, mcnt);
        end
    end

    task automatic do_reset;
        @(negedge clk); rst = 1'b1; hit = 1'b0; miss = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 step", step, 0);
        check("R1 level", level, 0);
        check("R1 count", hits, 0);
    endtask

    task automatic give_hits(input int k);
        for (int i = 0; i < k; i++) begin hit = 1'b1; @(negedge clk); end
        hit = 1'b0;
    endtask

    task automatic t_increment;
        do_reset();
        give_hits(5);
        check("R2 count after 5", hits, 5);
        check("R5 level at 5", level, 1);
    endtask

    task automatic t_saturate;
        do_reset();
        give_hits(20);
        check("R3 saturated", hits, 15);
        check("R5 level at 15", level, 3);
        give_hits(2);
        check("R3 still 15", hits, 15);
    endtask

    task automatic t_miss;
        do_reset();
        give_hits(9);
        miss = 1'b1; @(negedge clk); miss = 1'b0;
        check("R4 miss clears", hits, 0);
        check("R4 level slow", level, 0);
        give_hits(8);
        hit = 1'b1; miss = 1'b1; @(negedge clk); hit = 1'b0; miss = 1'b0;
        check("R4 miss wins", hits, 0);
        check("R4 level slow after tie", level, 0);
    endtask

    task automatic t_boundaries;
        do_reset();
        for (int c = 1; c <= 15; c++) begin
            give_hits(1);
            check("R5 boundary", level, map_lvl(c));
        end
    endtask

    task automatic t_interval(input int hits_wanted, input int lvl);
        int gap;
        do_reset();
        give_hits(hits_wanted);
        while (step !== 1'b1) @(negedge clk);
        gap = 0;
        do begin @(negedge clk); gap++; end while (step !== 1'b1 && gap < 100);
        check("R6 pulse spacing", gap, 2 * term_of(lvl));
    endtask

    task automatic t_switch;
        do_reset();
        for (int r = 0; r < 12; r++) begin
            repeat (r + 3) @(negedge clk);
            if (r % 4 == 3) begin miss = 1'b1; @(negedge clk); miss = 1'b0; end
            else give_hits(4);
        end
        repeat (40) @(negedge clk); // R7: monitor compares every cycle across switches
    endtask

    initial begin
        t_increment();
        t_saturate();
        t_miss();
        t_boundaries();
        t_interval(0, 0);
        t_interval(4, 1);
        t_interval(8, 2);
        t_interval(14, 3);
        t_switch();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #500000;
        if (!done) begin
            done = 1'b1;
            checks++; errors++;
            $display("FAIL watchdog actual 1 expected 0");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule